// File: doc/BRIEF.md
# Atomic Split Counter Read Controller

This block lets a 32-bit datapath read a 64-bit free-running counter as two back-to-back reads that together form a consistent 64-bit value. The first read, issued while the controller is idle, returns the low half of the counter and opens a two-clock window. During that window the controller masks the interrupt request going to the core, so nothing can be entered between the two halves. A read strobe in the second clock of the window returns the upper half. That upper half does not come from the live counter. It comes from a fixed two-stage delay line, so it belongs to the same counter value as the low half, even when the low half wrapped in between.

The controller is a three-state machine. IDLE is the rest state. HOLD1 is the first clock of interrupt holdoff and HOLD2 is the second. The transitions are: IDLE to HOLD1 on a read strobe (the low read), HOLD1 to HOLD2 unconditionally, and HOLD2 to IDLE unconditionally. A strobe in HOLD2 is the upper read. Because the pipeline depth matches the window length, the design needs no snapshot register for the upper half, and software never has to track wraps of the low half.

Top module: `split_read_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, the machine is in IDLE, `rd_data` is 0 and `rd_hi` is 0.
- R2: A strobe sampled in IDLE is a low read. At the next clock `rd_data` equals bits 31:0 of `cnt_in` as they stood at that sampling edge, and `rd_hi` is 0.
- R3: After a low read, `irq_take` is held at 0 for exactly the two following clocks (HOLD1 and HOLD2), whatever `irq_pending` does.
- R4: A strobe sampled in HOLD2 is an upper read. At the next clock `rd_data` equals bits 63:32 of `cnt_in` as they stood at the edge of the preceding low read, and `rd_hi` is 1.
- R5: An upper read starts no new holdoff. The machine returns to IDLE and `irq_take` again follows `irq_pending`.
- R6: A strobe sampled in HOLD1 is ignored: `rd_data` and `rd_hi` keep their values.
- R7: A strobe that arrives after the window has closed, with the machine back in IDLE, is a new low read. It returns low-half data with `rd_hi` 0 and starts a fresh holdoff.
- R8: Outside the holdoff window, `irq_take` equals `irq_pending` in the same cycle. A request held during holdoff is passed on as soon as the window ends, provided it is still pending.
- R9: Asserting reset in the middle of a holdoff returns the machine to IDLE, so `irq_take` follows `irq_pending` right after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_req | input | 1 | Counter read strobe, one cycle per read |
| irq_pending | input | 1 | Interrupt request from the interrupt controller |
| cnt_in | input | 64 | Free-running counter value |
| rd_data | output | 32 | Registered read result |
| rd_hi | output | 1 | 1 when `rd_data` holds the upper half |
| irq_take | output | 1 | Interrupt request after holdoff gating |

## Verification
The bench starts split reads just below a 32-bit wrap of the counter. If the upper half were taken from the live counter, or from a delay line of the wrong depth, it would come back one too high or one too low. The bench checks `irq_take` in each of the two holdoff clocks and in the clock after the window. A holdoff that is one clock short or long, or one restarted by the upper read, would pass or block an interrupt on the wrong edge. The bench also drives a strobe in HOLD1, a strobe that arrives late, and a reset in the middle of the window. A design that accepted the early strobe would overwrite the low data. One that treated the late strobe as an upper read would raise `rd_hi`. One that ignored reset would keep interrupts masked.

// File: rtl/split_rd_pkg.sv
`timescale 1ns/1ps
package split_rd_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_HOLD1 = 2'd1,
        ST_HOLD2 = 2'd2
    } rd_state_e;

    // Number of clocks that interrupts are masked after a low read; the
    // upper-half delay line has the same depth so both halves line up.
    localparam int HOLD_CLKS = 2;
endpackage

// File: rtl/split_rd_fsm.sv
`timescale 1ns/1ps
module split_rd_fsm
    import split_rd_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      rd_req,
    output rd_state_e state_q,
    output logic      take_low,
    output logic      take_high,
    output logic      in_hold
);
    rd_state_e state_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (rd_req) state_d = ST_HOLD1;
            ST_HOLD1: state_d = ST_HOLD2;
            ST_HOLD2: state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // decoded outputs
    always_comb begin
        take_low  = 1'b0;
        take_high = 1'b0;
        in_hold   = 1'b0;
        unique case (state_q)
            ST_IDLE:  take_low = rd_req;
            ST_HOLD1: in_hold  = 1'b1;
            ST_HOLD2: begin
                in_hold   = 1'b1;
                take_high = rd_req;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/hi_delay_line.sv
`timescale 1ns/1ps
module hi_delay_line #(
    parameter int W     = 32,
    parameter int DEPTH = 2
) (
    input  logic         clk,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stage [DEPTH];

    always_ff @(posedge clk) stage[0] <= din;

    for (genvar i = 1; i < DEPTH; i++) begin : g_stage
        always_ff @(posedge clk) stage[i] <= stage[i-1];
    end

    assign dout = stage[DEPTH-1];
endmodule

// File: rtl/split_read_ctrl.sv
`timescale 1ns/1ps
module split_read_ctrl
    import split_rd_pkg::*;
#(
    parameter int CNT_W = 64
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rd_req,
    input  logic               irq_pending,
    input  logic [CNT_W-1:0]   cnt_in,
    output logic [CNT_W/2-1:0] rd_data,
    output logic               rd_hi,
    output logic               irq_take
);
    localparam int HALF_W = CNT_W / 2;

    rd_state_e         state_q;
    logic              take_low;
    logic              take_high;
    logic              in_hold;
    logic [HALF_W-1:0] hi_aligned;

    split_rd_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_req    (rd_req),
        .state_q   (state_q),
        .take_low  (take_low),
        .take_high (take_high),
        .in_hold   (in_hold)
    );

    hi_delay_line #(.W(HALF_W), .DEPTH(HOLD_CLKS)) u_hi_dly (
        .clk  (clk),
        .din  (cnt_in[CNT_W-1:HALF_W]),
        .dout (hi_aligned)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
            rd_hi   <= 1'b0;
        end else if (take_low) begin
            rd_data <= cnt_in[HALF_W-1:0];
            rd_hi   <= 1'b0;
        end else if (take_high) begin
            rd_data <= hi_aligned;
            rd_hi   <= 1'b1;
        end
    end

    assign irq_take = irq_pending & ~in_hold;
endmodule

// File: rtl/split_read_chk.sv
`timescale 1ns/1ps
module split_read_chk
    import split_rd_pkg::*;
#(
    parameter int CNT_W = 64
) (
    input logic               clk,
    input logic               rst_n,
    input logic               rd_req,
    input logic               irq_pending,
    input logic [CNT_W-1:0]   cnt_in,
    input logic [CNT_W/2-1:0] rd_data,
    input logic               rd_hi,
    input logic               irq_take,
    input logic [1:0]         state_q
);
    localparam int HALF_W = CNT_W / 2;

    logic st_idle, st_hold1, st_hold2;
    assign st_idle  = (state_q == ST_IDLE);
    assign st_hold1 = (state_q == ST_HOLD1);
    assign st_hold2 = (state_q == ST_HOLD2);

    AST_LOW_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (st_idle && rd_req) |=> (!rd_hi && rd_data == $past(cnt_in[HALF_W-1:0]))); // R2
    AST_HOLD_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (st_idle && rd_req) |=> !irq_take); // R3
    AST_HOLD_SECOND: assert property (@(posedge clk) disable iff (!rst_n)
        st_hold1 |=> !irq_take); // R3
    AST_HI_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (st_hold2 && rd_req) |=> (rd_hi && rd_data == $past(cnt_in[CNT_W-1:HALF_W], 3))); // R4
    AST_NO_REHOLD: assert property (@(posedge clk) disable iff (!rst_n)
        st_hold2 |=> st_idle); // R5
    AST_HOLD1_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
        st_hold1 |=> ($stable(rd_data) && $stable(rd_hi))); // R6
    AST_TAKE_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        irq_take |-> irq_pending); // R8
endmodule

bind split_read_ctrl split_read_chk #(.CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .rd_req      (rd_req),
    .irq_pending (irq_pending),
    .cnt_in      (cnt_in),
    .rd_data     (rd_data),
    .rd_hi       (rd_hi),
    .irq_take    (irq_take),
    .state_q     (state_q)
);

// File: tb/split_read_ctrl_bench.sv
`timescale 1ns/1ps
module split_read_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rd_req = 1'b0;
    logic        irq_pending = 1'b0;
    logic [63:0] cnt_in = '0;
    logic [31:0] rd_data;
    logic        rd_hi;
    logic        irq_take;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    split_read_ctrl u_split_read_ctrl (
        .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .irq_pending(irq_pending),
        .cnt_in(cnt_in), .rd_data(rd_data), .rd_hi(rd_hi), .irq_take(irq_take)
    );

    // {counter value at the low read, irq_pending level}
    localparam logic [64:0] VEC [6] = '{
        {64'h0000_0005_FFFF_FFFF, 1'b1},
        {64'h0000_0005_FFFF_FFFE, 1'b0},
        {64'h1234_5678_9ABC_DEF0, 1'b1},
        {64'hFFFF_FFFF_FFFF_FFFF, 1'b1},
        {64'h0000_0000_0000_0000, 1'b0},
        {64'hA5A5_0000_7FFF_FFFF, 1'b1}
    };

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Low read, idle clock, upper read; counter advances by one per clock.
    task automatic split_read(input logic [63:0] base, input logic irq);
        @(negedge clk);
        cnt_in = base; rd_req = 1'b1; irq_pending = irq;
        #1 chk("R8 idle pass-through", irq_take, irq);
        @(negedge clk);                                  // now HOLD1
        chk("R2 low data", rd_data, base[31:0]);
        chk("R2 low flag", rd_hi, 0);
        chk("R3 holdoff clk1", irq_take, 0);
        cnt_in = base + 1; rd_req = 1'b0;
        @(negedge clk);                                  // now HOLD2
        chk("R3 holdoff clk2", irq_take, 0);
        cnt_in = base + 2; rd_req = 1'b1;
        @(negedge clk);                                  // back to IDLE
        chk("R4 upper data", rd_data, base[63:32]);
        chk("R4 upper flag", rd_hi, 1);
        chk("R5 no new holdoff", irq_take, irq);
        cnt_in = base + 3; rd_req = 1'b0;
        @(negedge clk);
        chk("R8 released", irq_take, irq);
    endtask

    initial begin
        logic [63:0] b;
        irq_pending = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 reset data", rd_data, 0);
        chk("R1 reset flag", rd_hi, 0);
        chk("R1 reset irq gate", irq_take, 1);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 idle after reset", irq_take, 1);

        foreach (VEC[i]) split_read(VEC[i][64:1], VEC[i][0]);

        // R6: strobe in HOLD1 is ignored
        b = 64'h0000_0009_FFFF_FFFF;
        @(negedge clk); cnt_in = b; rd_req = 1'b1; irq_pending = 1'b1;
        @(negedge clk); cnt_in = b + 1; rd_req = 1'b1;
        @(negedge clk);
        chk("R6 hold1 strobe data", rd_data, b[31:0]);
        chk("R6 hold1 strobe flag", rd_hi, 0);
        cnt_in = b + 2; rd_req = 1'b1;
        @(negedge clk);
        chk("R6 upper after ignored", rd_data, b[63:32]);
        rd_req = 1'b0;

        // R7: strobe after the window is a fresh low read
        b = 64'h0000_0003_0000_0010;
        @(negedge clk); cnt_in = b; rd_req = 1'b1;
        @(negedge clk); cnt_in = b + 1; rd_req = 1'b0;
        @(negedge clk); cnt_in = b + 2;
        @(negedge clk); cnt_in = b + 3;
        chk("R8 window closed", irq_take, 1);
        rd_req = 1'b1;
        @(negedge clk);
        chk("R7 late read flag", rd_hi, 0);
        chk("R7 late read data", rd_data, 32'h0000_0013);
        chk("R7 new holdoff", irq_take, 0);
        rd_req = 1'b0;
        repeat (2) @(negedge clk);

        // R9: reset in the middle of a holdoff
        @(negedge clk); cnt_in = 64'h55; rd_req = 1'b1;
        @(negedge clk); rd_req = 1'b0; rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        chk("R9 reset clears hold", irq_take, 1);
        chk("R9 reset clears data", rd_data, 0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule